// File: doc/BRIEF.md
# Program-Flow Discontinuity Trace Buffer

This block logs the program-flow jumps of a CPU into an on-chip circular memory. Each time the CPU reports a discontinuity, and tracing is both switched on by software and allowed by an external qualifier gate, the block stores two 32-bit words: the address the jump left from (source) and the address it landed on (destination). A word pointer advances by two per stored jump. A sticky flag records that the memory has filled at least once. After that, the pointer marks the oldest surviving pair of a wrapped log.

Software drives the block through a small register port. A control register holds the trace enable and a one-shot initialize command. Every write to the enable bit also records the current 22-bit CPU program counter: a write of 1 records it in the switch-on register and a write of 0 records it in the switch-off register. This gives readout tools a logical start and end for the trace. The trace memory can be read word by word through the same port.

Top module: `pc_flow_trace`

## Requirements
- R1: Register address 0 is the control register. Bit 0 is the trace enable and reads back as written. Bit 8 is the initialize command and always reads 0. All other bits read 0 whatever was written to them.
- R2: With enable=1 and qual_gate=1, a cycle with jump_vld=1 stores jump_src at word index ptr and jump_dst at word index ptr+1, then advances the pointer by 2.
- R3: A jump_vld cycle with enable=0 or qual_gate=0 stores nothing. The pointer stays unchanged and previously stored words are unchanged.
- R4: Register address 1 reads the pointer in bits 9:0 and the full flag in bit 15. Bits 14:10 and 31:16 read 0.
- R5: The memory holds 1024 words (512 pairs). The pointer wraps from 1022 to 0, and the full flag sets on that wrap. After a wrap, reading from index ptr to 1023 and then from 0 to ptr-1 gives the retained pairs from oldest to newest.
- R6: The full flag is sticky. Only an initialize command or reset clears it. Disabling the trace does not clear it.
- R7: Any control write with bit 0 = 1 captures cpu_pc[21:0] into register address 2. Any control write with bit 0 = 0 captures cpu_pc into register address 3. Bits 31:22 of both registers read 0.
- R8: A control write with bit 8 = 1 clears the pointer, the full flag and both captured-PC registers. The enable takes the value of bit 0 of the same write.
- R9: When an initialize command and an accepted jump occur in the same cycle, the initialize wins: nothing is stored and the pointer reads 0 afterwards.
- R10: Register address 4 returns the trace memory word selected by reg_idx.
- R11: After reset, the enable, pointer, full flag and both captured-PC registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_pc | input | 22 | Current CPU program counter |
| jump_vld | input | 1 | Discontinuity strobe, one cycle per jump |
| jump_src | input | 32 | Address the jump left from |
| jump_dst | input | 32 | Address the jump landed on |
| qual_gate | input | 1 | External qualifier; jumps are logged only while high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 pointer, 2 switch-on PC, 3 switch-off PC, 4 trace word |
| reg_wdata | input | 32 | Register write data |
| reg_idx | input | 10 | Trace word index for address 4 |
| reg_rdata | output | 32 | Combinational read data |

## Verification
The bench fills the memory past capacity by three pairs and walks the log from the pointer through the wrap. A design that wrapped at the wrong index, set the full flag one pair early or late, or swapped source and destination would show a misordered or shifted sequence. It also checks that the full flag survives a disable. It fires an initialize in the same cycle as an accepted jump, which catches a pointer that advances through the clear. Jumps that arrive with the gate low or the enable off are checked against an unmoved pointer and unchanged stored words. A reset after the full flag has set is checked for a clean restart.

// File: rtl/pft_pkg.sv
// Package: shared constants and register-select codes for the trace buffer.
// Assumes a 32-bit register port.
package pft_pkg;
    localparam int REG_W         = 32;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_INIT_BIT = 8;
    localparam int PTR_FULL_BIT  = 15;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_PTR    = 3'd1,
        RA_PC_ON  = 3'd2,
        RA_PC_OFF = 3'd3,
        RA_WORD   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/pft_ctrl.sv
// Module: pft_ctrl
// Holds the trace enable and the two captured-PC registers, and decodes the
// one-shot initialize command from a control write.
// Assumes ctrl_wr is high for one cycle per software write.
module pft_ctrl
    import pft_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic [PC_W-1:0]  cpu_pc,
    output logic             trace_en,
    output logic             init_pulse,
    output logic [PC_W-1:0]  pc_on,
    output logic [PC_W-1:0]  pc_off
);
    logic wr_en_bit;
    logic unused_wdata;

    assign wr_en_bit    = ctrl_wdata[CTRL_EN_BIT];
    assign init_pulse   = ctrl_wr & ctrl_wdata[CTRL_INIT_BIT];
    assign unused_wdata = ^ctrl_wdata;

    // Update enable on every control write; capture PC unless init clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_en <= 1'b0;
            pc_on    <= '0;
            pc_off   <= '0;
        end else if (ctrl_wr) begin
            trace_en <= wr_en_bit;
            if (init_pulse) begin
                pc_on  <= '0;
                pc_off <= '0;
            end else if (wr_en_bit) begin
                pc_on  <= cpu_pc;
            end else begin
                pc_off <= cpu_pc;
            end
        end
    end
endmodule

// File: rtl/pft_wptr.sv
// Module: pft_wptr
// Word pointer that steps by two per stored pair, plus a sticky full flag
// that sets when the pointer wraps from the last pair to zero.
// Assumes store is never asserted in a cycle where init is asserted.
module pft_wptr #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             store,
    output logic [PTR_W-1:0] ptr,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST_PAIR = PTR_W'((1 << PTR_W) - 2);
    localparam logic [PTR_W-1:0] STEP      = PTR_W'(2);

    // Advance, wrap and flag the pointer; init restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            full <= 1'b0;
        end else if (init) begin
            ptr  <= '0;
            full <= 1'b0;
        end else if (store) begin
            ptr <= ptr + STEP;
            if (ptr == LAST_PAIR) begin
                full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pft_store.sv
// Module: pft_store
// Trace memory organised as two banks, one for source words and one for
// destination words, so a whole pair is written in a single cycle.
// Word index bit 0 selects the bank on read. Contents are not reset.
module pft_store #(
    parameter int DW    = 32,
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-2:0] wr_pair,
    input  logic [DW-1:0]    src,
    input  logic [DW-1:0]    dst,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_word
);
    localparam int PAIRS = 1 << (PTR_W - 1);

    logic [1:0][DW-1:0] rd_bank;
    logic [PTR_W-2:0]   rd_pair;

    assign rd_pair = rd_idx[PTR_W-1:1];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DW-1:0] bank [PAIRS];
        logic [DW-1:0] wval;

        assign wval = (b == 0) ? src : dst;

        // Write this bank's half of the pair.
        always_ff @(posedge clk) begin
            if (we) begin
                bank[wr_pair] <= wval;
            end
        end

        assign rd_bank[b] = bank[rd_pair];
    end

    assign rd_word = rd_bank[rd_idx[0]];
endmodule

// File: rtl/pc_flow_trace.sv
// Module: pc_flow_trace (top)
// Logs program-flow discontinuities as source/destination pairs in a
// circular memory and exposes control, pointer, captured PCs and trace
// words through a combinational register read port.
// Assumes jump_vld is a one-cycle strobe per discontinuity and DW <= 32.
module pc_flow_trace
    import pft_pkg::*;
#(
    parameter int PC_W  = 22,
    parameter int PTR_W = 10,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  cpu_pc,
    input  logic             jump_vld,
    input  logic [DW-1:0]    jump_src,
    input  logic [DW-1:0]    jump_dst,
    input  logic             qual_gate,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [PTR_W-1:0] reg_idx,
    output logic [REG_W-1:0] reg_rdata
);
    logic             ctrl_wr;
    logic             trace_en;
    logic             init_pulse;
    logic             store;
    logic [PC_W-1:0]  pc_on_q;
    logic [PC_W-1:0]  pc_off_q;
    logic [PTR_W-1:0] wr_ptr;
    logic             buf_full;
    logic [DW-1:0]    rd_word;

    assign ctrl_wr = reg_wr && (reg_addr_e'(reg_addr) == RA_CTRL);
    assign store   = jump_vld & qual_gate & trace_en & ~init_pulse;

    pft_ctrl #(.PC_W(PC_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (reg_wdata),
        .cpu_pc     (cpu_pc),
        .trace_en   (trace_en),
        .init_pulse (init_pulse),
        .pc_on      (pc_on_q),
        .pc_off     (pc_off_q)
    );

    pft_wptr #(.PTR_W(PTR_W)) wptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (init_pulse),
        .store (store),
        .ptr   (wr_ptr),
        .full  (buf_full)
    );

    pft_store #(.DW(DW), .PTR_W(PTR_W)) store_i (
        .clk     (clk),
        .we      (store),
        .wr_pair (wr_ptr[PTR_W-1:1]),
        .src     (jump_src),
        .dst     (jump_dst),
        .rd_idx  (reg_idx),
        .rd_word (rd_word)
    );

    // Select read data by register address; unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_CTRL:   reg_rdata[CTRL_EN_BIT] = trace_en;
            RA_PTR: begin
                reg_rdata[PTR_W-1:0]   = wr_ptr;
                reg_rdata[PTR_FULL_BIT] = buf_full;
            end
            RA_PC_ON:  reg_rdata = REG_W'(pc_on_q);
            RA_PC_OFF: reg_rdata = REG_W'(pc_off_q);
            RA_WORD:   reg_rdata = REG_W'(rd_word);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pft_chk.sv
// Module: pft_chk
// Property checker for pc_flow_trace, attached by bind below.
module pft_chk #(
    parameter int PC_W  = 22,
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             jump_vld,
    input logic             qual_gate,
    input logic             trace_en,
    input logic             init_pulse,
    input logic             ctrl_wr,
    input logic [31:0]      reg_wdata,
    input logic [PC_W-1:0]  cpu_pc,
    input logic [PC_W-1:0]  pc_on_q,
    input logic [PC_W-1:0]  pc_off_q,
    input logic [PTR_W-1:0] wr_ptr,
    input logic             buf_full,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_rdata
);
    localparam logic [PTR_W-1:0] LAST_PAIR = PTR_W'((1 << PTR_W) - 2);

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_vld && qual_gate && trace_en && !init_pulse)
        |=> wr_ptr == PTR_W'($past(wr_ptr) + PTR_W'(2)));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!jump_vld || !qual_gate || !trace_en) && !init_pulse)
        |=> $stable(wr_ptr));

    // R5
    wrap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_vld && qual_gate && trace_en && !init_pulse && wr_ptr == LAST_PAIR)
        |=> (buf_full && wr_ptr == '0));

    // R6
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !init_pulse) |=> buf_full);

    // R8
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (wr_ptr == '0 && !buf_full && pc_on_q == '0 && pc_off_q == '0));

    // R7
    pc_on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[0] && !reg_wdata[8]) |=> pc_on_q == $past(cpu_pc));

    // R7
    pc_off_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[0] && !reg_wdata[8]) |=> pc_off_q == $past(cpu_pc));

    // R1
    init_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> (reg_rdata[31:1] == '0));
endmodule

bind pc_flow_trace pft_chk #(.PC_W(PC_W), .PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .jump_vld   (jump_vld),
    .qual_gate  (qual_gate),
    .trace_en   (trace_en),
    .init_pulse (init_pulse),
    .ctrl_wr    (ctrl_wr),
    .reg_wdata  (reg_wdata),
    .cpu_pc     (cpu_pc),
    .pc_on_q    (pc_on_q),
    .pc_off_q   (pc_off_q),
    .wr_ptr     (wr_ptr),
    .buf_full   (buf_full),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/pc_flow_trace_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: jump driver pushes expected pairs, log monitor pops them
// while walking trace memory in oldest-to-newest order.
module pc_flow_trace_tb_top;
    localparam int NPAIRS = 512;
    localparam int NWORDS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] cpu_pc = '0;
    logic        jump_vld = 1'b0;
    logic [31:0] jump_src = '0;
    logic [31:0] jump_dst = '0;
    logic        qual_gate = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [9:0]  reg_idx = '0;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit en_m    = 1'b0;
    logic [63:0] exp_q [$];

    always #5 clk = ~clk;

    pc_flow_trace dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_pc(cpu_pc), .jump_vld(jump_vld),
        .jump_src(jump_src), .jump_dst(jump_dst), .qual_gate(qual_gate),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_idx(reg_idx), .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input int idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_idx  = 10'(idx);
        #1 d = reg_rdata;
    endtask

    task automatic wr_ctrl(input logic [31:0] w, input logic [21:0] pc);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = w; cpu_pc = pc;
        @(negedge clk);
        reg_wr = 1'b0;
        en_m = w[0];
        if (w[8]) exp_q.delete();
    endtask

    // Driver: apply one jump and push the expected pair when it is accepted.
    task automatic jump(input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        jump_vld = 1'b1; jump_src = s; jump_dst = d;
        @(negedge clk);
        jump_vld = 1'b0;
        if (en_m && qual_gate) begin
            exp_q.push_back({d, s});
            if (exp_q.size() > NPAIRS) void'(exp_q.pop_front());
        end
    endtask

    // Monitor: walk the log from the oldest pair and pop each expected pair.
    task automatic drain_log(input string tag);
        logic [31:0] p, v;
        logic [63:0] e;
        int start;
        rd(3'd1, 0, p);
        start = p[15] ? int'(p[9:0]) : 0;
        for (int k = 0; exp_q.size() > 0; k++) begin
            e = exp_q.pop_front();
            rd(3'd4, (start + 2 * k) % NWORDS, v);
            check({tag, " src"}, v, e[31:0]);
            rd(3'd4, (start + 2 * k + 1) % NWORDS, v);
            check({tag, " dst"}, v, e[63:32]);
        end
    endtask

    function automatic logic [31:0] sv_src(input int k);
        return 32'h1000_0000 + 32'(k);
    endfunction
    function automatic logic [31:0] sv_dst(input int k);
        return 32'h2000_0000 ^ (32'(k) * 32'd3);
    endfunction

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(3'd0, 0, v); check("R11 ctrl", v, 32'h0);
        rd(3'd1, 0, v); check("R11 ptr", v, 32'h0);
        rd(3'd2, 0, v); check("R11 pc_on", v, 32'h0);
        rd(3'd3, 0, v); check("R11 pc_off", v, 32'h0);

        // R1 / R7 enable with junk bits, PC captured
        wr_ctrl(32'hFFFF_FEFF, 22'h2A_BCDE);
        rd(3'd0, 0, v); check("R1 ctrl readback", v, 32'h1);
        rd(3'd2, 0, v); check("R7 pc_on", v, 32'h002A_BCDE);

        // R2 / R10 three accepted jumps
        qual_gate = 1'b1;
        for (int k = 0; k < 3; k++) jump(sv_src(k), sv_dst(k));
        rd(3'd1, 0, v); check("R2 ptr after 3", v, 32'd6);
        rd(3'd4, 0, w0); check("R2 word0 src", w0, sv_src(0));
        rd(3'd4, 5, v); check("R10 word5 dst", v, sv_dst(2));

        // R3 gate low, then enable off
        qual_gate = 1'b0;
        jump(32'hDEAD_0001, 32'hDEAD_0002);
        rd(3'd1, 0, v); check("R3 ptr gate low", v, 32'd6);
        qual_gate = 1'b1;
        wr_ctrl(32'h0, 22'h01_2345);
        rd(3'd3, 0, v); check("R7 pc_off", v, 32'h0001_2345);
        rd(3'd2, 0, v); check("R7 pc_on kept", v, 32'h002A_BCDE);
        jump(32'hDEAD_0003, 32'hDEAD_0004);
        rd(3'd1, 0, v); check("R3 ptr disabled", v, 32'd6);
        rd(3'd4, 0, v); check("R3 word0 intact", v, w0);
        drain_log("R2 log");

        // R8 init with enable
        wr_ctrl(32'h0000_0101, 22'h3F_0000);
        rd(3'd1, 0, v); check("R8 ptr cleared", v, 32'h0);
        rd(3'd2, 0, v); check("R8 pc_on cleared", v, 32'h0);
        rd(3'd3, 0, v); check("R8 pc_off cleared", v, 32'h0);
        rd(3'd0, 0, v); check("R1 init reads 0", v, 32'h1);

        // R5 fill exactly, then wrap by three pairs
        for (int k = 0; k < NPAIRS; k++) jump(sv_src(k), sv_dst(k));
        rd(3'd1, 0, v); check("R5 just full", v, 32'h0000_8000);
        for (int k = NPAIRS; k < NPAIRS + 3; k++) jump(sv_src(k), sv_dst(k));
        rd(3'd1, 0, v); check("R4 R5 wrapped ptr", v, 32'h0000_8006);
        drain_log("R5 wrap order");

        // R6 sticky across disable
        wr_ctrl(32'h0, 22'h0);
        rd(3'd1, 0, v); check("R6 full after disable", v, 32'h0000_8006);

        // R9 init and accepted jump in the same cycle
        wr_ctrl(32'h1, 22'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h101;
        jump_vld = 1'b1; jump_src = 32'hAAAA_0000; jump_dst = 32'hBBBB_0000;
        @(negedge clk);
        reg_wr = 1'b0; jump_vld = 1'b0; exp_q.delete();
        rd(3'd1, 0, v); check("R9 init wins", v, 32'h0);
        jump(sv_src(7), sv_dst(7));
        rd(3'd1, 0, v); check("R9 next store", v, 32'd2);
        drain_log("R9 log");

        // R6 reset clears full
        for (int k = 0; k < NPAIRS; k++) jump(sv_src(k), sv_dst(k));
        rd(3'd1, 0, v); check("R6 full before reset", v, 32'h0000_8002);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        en_m = 1'b0; exp_q.delete();
        rd(3'd1, 0, v); check("R6 R11 reset clears", v, 32'h0);
        rd(3'd0, 0, v); check("R11 enable cleared", v, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule